// File: doc/BRIEF.md
# Host-Refreshed Programmable Watchdog Timer

This block watches a host controller that must prove it is still running. The host refreshes the watchdog by writing to a refresh strobe. It can also write a configuration word that holds an enable bit and a timeout interval. The interval is counted in periods of an external time-base strobe, nominally one pulse every 100 ms. The default interval is 100 such periods, which is 10 seconds.

If the interval runs out with no refresh, the block drives an active-low reset pulse of fixed width towards the host. At the same moment it emits a one-cycle clear. Neighbouring register blocks use that clear to drop out of their self-test mode.

The watchdog's own reset pulse has the same effect on its configuration as power-on reset: the watchdog comes back enabled with the 10-second default. While the pulse is in progress the block ignores the host. The countdown then resumes from the default interval.

Top module: `host_watchdog`

## Requirements
- R1: After power-on reset, the outputs are as follows: `cfg_en`=1, `cfg_ival`=100, `remaining`=100, `wd_rst_n`=1 and `test_clr`=0.
- R2: When the watchdog is enabled and idle, each cycle with `tick`=1 and no other write lowers `remaining` by one, as long as `remaining` is above 1.
- R3: A timeout occurs on the N-th tick after a reload to interval N, or on the first tick when N is 0 or 1. From the cycle after that tick, `wd_rst_n` is low for exactly 16 clock cycles.
- R4: At a timeout, the next cycle shows `cfg_en`=1, `cfg_ival`=100 and `remaining`=100. `test_clr` is high only in the first low cycle of the pulse.
- R5: A refresh (`kick_wr`=1) while enabled and idle reloads `remaining` from `cfg_ival`. A refresh takes priority over a tick in the same cycle.
- R6: A configuration write (`cfg_wr`=1) while idle stores `cfg_wdata[8]` as the enable bit and `cfg_wdata[7:0]` as the interval. The same write reloads `remaining` with the new interval, taking priority over a tick and a refresh in the same cycle.
- R7: While disabled (`cfg_en`=0), ticks and refreshes leave `remaining` unchanged and no pulse occurs. A write that enables the watchdog again reloads `remaining` from the written interval.
- R8: While `wd_rst_n` is low, ticks, refreshes and configuration writes have no effect: the configuration stays at its default and `remaining` stays at 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| tick | input | 1 | Time-base strobe, one cycle per interval unit |
| kick_wr | input | 1 | Host refresh write strobe |
| cfg_wr | input | 1 | Host configuration write strobe |
| cfg_wdata | input | 9 | Configuration word: bit 8 is the enable bit, bits 7:0 are the interval in ticks |
| cfg_en | output | 1 | Stored enable bit |
| cfg_ival | output | 8 | Stored interval |
| remaining | output | 8 | Ticks left before a timeout |
| wd_rst_n | output | 1 | Watchdog reset pulse, active low |
| test_clr | output | 1 | One-cycle clear for self-test enables in other blocks |

## Verification
Every register in this block sits one edge behind its cause:
- A tick, refresh or configuration write shows on `remaining` and the configuration outputs at the first edge after it.
- A timeout tick drives `wd_rst_n` low and raises `test_clr` at that same edge. The pulse stays low through sixteen edges.

The bench drives each input just after a falling edge and samples on the next falling edge. Every result is therefore read exactly one cycle after its cause.

The pulse width is measured by counting low samples on successive falling edges. The number of ticks to a timeout is swept over a range of small intervals, and the expected count comes from the interval value alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [2:0] {
    LD_HOLD = 3'd0,
    LD_CFG  = 3'd1,
    LD_KICK = 3'd2,
    LD_DEF  = 3'd3,
    LD_DEC  = 3'd4
  } wdt_load_e;

  // A tick that arrives with this many ticks left ends the interval.
  function automatic logic at_end(input int unsigned left);
    return (left <= 32'd1);
  endfunction

  // Next countdown value for a given load selection.
  function automatic int unsigned next_count(input wdt_load_e sel,
                                             input int unsigned cur,
                                             input int unsigned new_ival,
                                             input int unsigned cur_ival,
                                             input int unsigned def_ival);
    int unsigned r;
    case (sel)
      LD_CFG:  r = new_ival;
      LD_KICK: r = cur_ival;
      LD_DEF:  r = def_ival;
      LD_DEC:  r = (cur == 32'd0) ? 32'd0 : cur - 32'd1;
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
  parameter int IW       = 8,
  parameter int DEF_IVAL = 100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restore,
  input  logic          accept,
  input  logic [IW:0]   wdata,
  output logic          en,
  output logic [IW-1:0] ival
);

  localparam logic [IW-1:0] DEF_V = IW'(DEF_IVAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= 1'b1;
      ival <= DEF_V;
    end else if (restore) begin
      en   <= 1'b1;
      ival <= DEF_V;
    end else if (accept) begin
      en   <= wdata[IW];
      ival <= wdata[IW-1:0];
    end
  end

endmodule

// File: rtl/wdt_event_decode.sv
module wdt_event_decode (
  input  logic               cfg_wr,
  input  logic               kick_wr,
  input  logic               tick,
  input  logic               en,
  input  logic               busy,
  input  logic               last,
  output wdt_pkg::wdt_load_e sel,
  output logic               expire,
  output logic               cfg_accept
);

  import wdt_pkg::*;

  always_comb begin
    sel        = LD_HOLD;
    expire     = 1'b0;
    cfg_accept = 1'b0;
    if (busy) begin
      sel = LD_HOLD;
    end else if (cfg_wr) begin
      sel        = LD_CFG;
      cfg_accept = 1'b1;
    end else if (en && kick_wr) begin
      sel = LD_KICK;
    end else if (en && tick && last) begin
      sel    = LD_DEF;
      expire = 1'b1;
    end else if (en && tick) begin
      sel = LD_DEC;
    end
  end

endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int IW       = 8,
  parameter int DEF_IVAL = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wdt_pkg::wdt_load_e sel,
  input  logic [IW-1:0]      new_ival,
  input  logic [IW-1:0]      cur_ival,
  output logic [IW-1:0]      count,
  output logic               last
);

  localparam logic [IW-1:0] DEF_V = IW'(DEF_IVAL);

  logic [IW-1:0] count_nx;

  always_comb begin
    count_nx = IW'(wdt_pkg::next_count(sel, 32'(count), 32'(new_ival),
                                       32'(cur_ival), 32'(DEF_V)));
    last     = wdt_pkg::at_end(32'(count));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= DEF_V;
    else        count <= count_nx;
  end

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int PULSE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic rst_n_o,
  output logic clr_o,
  output logic busy
);

  localparam int PCW = $clog2(PULSE_W + 1);
  localparam logic [PCW-1:0] PW_V = PCW'(PULSE_W);

  logic [PCW-1:0] pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pcnt <= '0;
    else if (fire)          pcnt <= PW_V;
    else if (pcnt != '0)    pcnt <= pcnt - 1'b1;
  end

  always_comb begin
    busy    = (pcnt != '0);
    rst_n_o = ~busy;
    clr_o   = (pcnt == PW_V);
  end

endmodule

// File: rtl/host_watchdog.sv
module host_watchdog #(
  parameter int IW       = 8,
  parameter int DEF_IVAL = 100,
  parameter int PULSE_W  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          kick_wr,
  input  logic          cfg_wr,
  input  logic [IW:0]   cfg_wdata,
  output logic          cfg_en,
  output logic [IW-1:0] cfg_ival,
  output logic [IW-1:0] remaining,
  output logic          wd_rst_n,
  output logic          test_clr
);

  wdt_pkg::wdt_load_e load_sel;
  logic expire_evt;
  logic cfg_accept;
  logic busy;
  logic last_tick;

  wdt_event_decode u_dec (
    .cfg_wr     (cfg_wr),
    .kick_wr    (kick_wr),
    .tick       (tick),
    .en         (cfg_en),
    .busy       (busy),
    .last       (last_tick),
    .sel        (load_sel),
    .expire     (expire_evt),
    .cfg_accept (cfg_accept)
  );

  wdt_cfg_reg #(.IW(IW), .DEF_IVAL(DEF_IVAL)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .restore (expire_evt),
    .accept  (cfg_accept),
    .wdata   (cfg_wdata),
    .en      (cfg_en),
    .ival    (cfg_ival)
  );

  wdt_countdown #(.IW(IW), .DEF_IVAL(DEF_IVAL)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (load_sel),
    .new_ival (cfg_wdata[IW-1:0]),
    .cur_ival (cfg_ival),
    .count    (remaining),
    .last     (last_tick)
  );

  wdt_pulse_gen #(.PULSE_W(PULSE_W)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (expire_evt),
    .rst_n_o (wd_rst_n),
    .clr_o   (test_clr),
    .busy    (busy)
  );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int IW       = 8,
  parameter int DEF_IVAL = 100,
  parameter int PULSE_W  = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          kick_wr,
  input logic          cfg_wr,
  input logic          cfg_en,
  input logic [IW-1:0] cfg_ival,
  input logic [IW-1:0] remaining,
  input logic          wd_rst_n,
  input logic          test_clr
);

  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_cnt <= 0;
    else if (!wd_rst_n) low_cnt <= low_cnt + 1;
    else               low_cnt <= 0;
  end

  assert_tick_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg_en && wd_rst_n && !kick_wr && !cfg_wr && remaining > 1)
      |=> (remaining == $past(remaining) - 1'b1));

  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst_n) |-> (low_cnt == PULSE_W));

  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_rst_n |-> (low_cnt < PULSE_W));

  assert_cfg_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wd_rst_n) |-> (cfg_en && cfg_ival == IW'(DEF_IVAL)
                         && remaining == IW'(DEF_IVAL) && test_clr));

  assert_clr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    test_clr |=> (!test_clr && !wd_rst_n));

  assert_kick_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_wr && cfg_en && wd_rst_n && !cfg_wr) |=> (remaining == $past(cfg_ival)));

  assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && wd_rst_n && !cfg_wr) |=> ($stable(remaining) && wd_rst_n));

  assert_pulse_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_rst_n |=> ($stable(cfg_ival) && $stable(cfg_en) && $stable(remaining)));

endmodule

bind host_watchdog wdt_checker #(.IW(IW), .DEF_IVAL(DEF_IVAL), .PULSE_W(PULSE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .kick_wr   (kick_wr),
  .cfg_wr    (cfg_wr),
  .cfg_en    (cfg_en),
  .cfg_ival  (cfg_ival),
  .remaining (remaining),
  .wd_rst_n  (wd_rst_n),
  .test_clr  (test_clr)
);

// File: tb/sim_host_watchdog.sv
`timescale 1ns/1ps
module sim_host_watchdog;

  localparam int IW = 8;
  localparam int DEF = 100;
  localparam int PW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, kick_wr = 1'b0, cfg_wr = 1'b0;
  logic [IW:0] cfg_wdata = '0;
  logic cfg_en, wd_rst_n, test_clr;
  logic [IW-1:0] cfg_ival, remaining;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  host_watchdog #(.IW(IW), .DEF_IVAL(DEF), .PULSE_W(PW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .kick_wr(kick_wr),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_en(cfg_en),
    .cfg_ival(cfg_ival), .remaining(remaining), .wd_rst_n(wd_rst_n),
    .test_clr(test_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the following falling edge.
  task automatic step(input logic t, input logic k, input logic w, input int en, input int iv);
    tick = t; kick_wr = k; cfg_wr = w;
    cfg_wdata = {1'(en), IW'(iv)};
    @(posedge clk);
    @(negedge clk);
    tick = 1'b0; kick_wr = 1'b0; cfg_wr = 1'b0;
  endtask

  // Called at the first low sample; counts low samples and clear samples.
  task automatic measure(output int lows, output int clrs);
    lows = 0; clrs = 0;
    while (!wd_rst_n && lows < 200) begin
      lows++;
      if (test_clr) clrs++;
      step(0, 0, 0, 0, 0);
    end
  endtask

  task automatic check_timeout(input string tag);
    int lows, clrs;
    chk({tag, " R3 pulse start"}, int'(wd_rst_n), 0);
    chk({tag, " R4 clr first"}, int'(test_clr), 1);
    chk({tag, " R4 cfg_en"}, int'(cfg_en), 1);
    chk({tag, " R4 cfg_ival"}, int'(cfg_ival), DEF);
    chk({tag, " R4 remaining"}, int'(remaining), DEF);
    measure(lows, clrs);
    chk({tag, " R3 width"}, lows, PW);
    chk({tag, " R4 clr count"}, clrs, 1);
  endtask

  initial begin
    int lows, clrs;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_en", int'(cfg_en), 1);
    chk("R1 cfg_ival", int'(cfg_ival), DEF);
    chk("R1 remaining", int'(remaining), DEF);
    chk("R1 wd_rst_n", int'(wd_rst_n), 1);
    chk("R1 test_clr", int'(test_clr), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R3 default interval runs out after 100 ticks
    for (int k = 1; k < DEF; k++) begin
      step(1, 0, 0, 0, 0);
      chk("R2 default dec", int'(remaining), DEF - k);
      chk("R3 no early pulse", int'(wd_rst_n), 1);
    end
    step(1, 0, 0, 0, 0);
    check_timeout("default");

    // R3/R6 sweep of intervals, with idle gaps between ticks
    for (int n = 0; n <= 12; n++) begin
      step(0, 0, 1, 1, n);
      chk("R6 cfg_ival", int'(cfg_ival), n);
      chk("R6 reload", int'(remaining), n);
      for (int k = 1; k < n; k++) begin
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        chk("R2 sweep dec", int'(remaining), n - k);
        chk("R3 sweep no pulse", int'(wd_rst_n), 1);
      end
      step(1, 0, 0, 0, 0);
      check_timeout("sweep");
    end

    // R5 refresh, and refresh over a same-cycle tick
    step(0, 0, 1, 1, 10);
    repeat (4) step(1, 0, 0, 0, 0);
    chk("R2 before kick", int'(remaining), 6);
    step(0, 1, 0, 0, 0);
    chk("R5 kick reload", int'(remaining), 10);
    repeat (3) step(1, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    chk("R5 kick over tick", int'(remaining), 10);
    step(1, 0, 0, 0, 0);
    chk("R5 after kick", int'(remaining), 9);

    // R6 write over tick and kick
    step(1, 1, 1, 1, 7);
    chk("R6 priority", int'(remaining), 7);
    chk("R6 en", int'(cfg_en), 1);

    // R7 disabled
    step(0, 0, 1, 0, 5);
    chk("R7 disabled en", int'(cfg_en), 0);
    chk("R7 disable reload", int'(remaining), 5);
    for (int k = 0; k < 20; k++) step(1, 0, 0, 0, 0);
    chk("R7 tick hold", int'(remaining), 5);
    chk("R7 no pulse", int'(wd_rst_n), 1);
    step(0, 1, 0, 0, 0);
    chk("R7 kick hold", int'(remaining), 5);
    step(0, 0, 1, 1, 3);
    chk("R7 reenable reload", int'(remaining), 3);
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk("R7 counting again", int'(remaining), 1);
    step(1, 0, 0, 0, 0);
    check_timeout("reenable");

    // R8 host activity during the pulse is ignored
    step(0, 0, 1, 1, 1);
    step(1, 0, 0, 0, 0);
    chk("R8 pulse start", int'(wd_rst_n), 0);
    lows = 0; clrs = 0;
    while (!wd_rst_n && lows < 200) begin
      lows++;
      if (test_clr) clrs++;
      case (lows % 3)
        0: step(0, 0, 1, 0, 5);
        1: step(0, 1, 0, 0, 0);
        default: step(1, 0, 0, 0, 0);
      endcase
      chk("R8 cfg_ival", int'(cfg_ival), DEF);
      chk("R8 cfg_en", int'(cfg_en), 1);
      chk("R8 remaining", int'(remaining), DEF);
    end
    chk("R8 width", lows, PW);
    chk("R8 clr count", clrs, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule